// File: doc/BRIEF.md
# Zero-Page Single-Bit Set/Clear Sequencer

This block carries out the single-bit modify instructions of an 8-bit processor on a byte in zero page. The core hands it an opcode that has already been fetched, together with the address of that opcode, and pulses `start`. The sequencer then runs the rest of the instruction on a simple synchronous memory bus. It reads the one-byte zero-page operand, reads the target byte, repeats that read as a dummy cycle, and writes the byte back with exactly one bit forced to 0 or 1. It pulses `done` during the write cycle.

The opcode alone picks the variant. Opcode bits 6:4 give the bit number, and opcode bit 7 chooses between set and clear. Every legal opcode has the low nibble 7. When `start` arrives with any other opcode, the block raises `illegal` for that cycle and stays idle. No flag, accumulator or other processor state is involved.

The bus is synchronous. `mem_rdata` must hold the byte at `mem_addr` in any cycle where `mem_rd` is high, and the sequencer samples it at the clock edge that closes that cycle. A write takes effect at the clock edge that closes the cycle where `mem_wr` is high.

Top module: `zp_bitop_seq`

## Requirements
- R1: An opcode is legal only when its bits 3:0 equal 4'h7. When `start` is high in the idle state with an illegal opcode, `illegal` is high in that same cycle only, and no read or write strobe follows.
- R2: Opcode bit 7 selects the operation: 1 sets the chosen bit and 0 clears it.
- R3: Opcode bits 6:4 give the number of the bit that is modified (0 to 7).
- R4: A legal start is accepted in the idle state. In the next cycle (cycle 2) the block reads the operand at the opcode address plus one.
- R5: In cycles 3 and 4 the block reads the address {8'h00, operand}. Cycle 4 repeats the read of cycle 3 at the same address.
- R6: In cycle 5 the block writes to the same zero-page address the byte it sampled in cycle 3, with only the selected bit changed. All other bits and all other memory locations are preserved.
- R7: The write strobe is high only in cycle 5 and the read strobe only in cycles 2 to 4. The two strobes are never high together.
- R8: `done` is high for exactly one cycle, in cycle 5. The block is idle again in the cycle after that and can accept a new start there.
- R9: `start` is ignored while an instruction is in progress.
- R10: A synchronous active-high `rst` returns the block to idle, even in the middle of an instruction. While idle, `mem_rd`, `mem_wr`, `done` and `illegal` are low unless `start` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing `opcode` (sampled in the idle state only) |
| opcode | input | 8 | Opcode byte that has already been fetched |
| pc | input | 16 | Address of the opcode byte |
| mem_addr | output | 16 | Bus address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for the current read cycle |
| done | output | 1 | Instruction completes (write cycle) |
| illegal | output | 1 | Start with an opcode that is not legal |

## Verification
Take the cycle in which `start` is sampled as cycle 1. The operand read is due one cycle later. The two zero-page reads are due two and three cycles later. The write and `done` are due four cycles later. `illegal` is due in cycle 1 itself. The bench's reference model advances its own phase counter at each rising edge and predicts every output for the cycle that follows. It compares the outputs a few nanoseconds after each falling edge, once both the registered and the combinational outputs have settled, so every prediction is checked in exactly the cycle it names. After all instructions have run, the bench compares its memory image against the model's image to catch writes to the wrong place and any disturbed bits.

// File: rtl/zpb_pkg.sv
package zpb_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPND,
    ST_READ,
    ST_DUMMY,
    ST_WRITE
  } seq_state_t;

  typedef struct packed {
    logic             set;
    logic [IDX_W-1:0] idx;
  } bitop_t;

  function automatic logic op_is_legal(input logic [DATA_W-1:0] op);
    return op[3:0] == 4'h7;
  endfunction

  function automatic bitop_t op_fields(input logic [DATA_W-1:0] op);
    bitop_t f;
    f.set = op[7];
    f.idx = op[6:4];
    return f;
  endfunction

  function automatic logic [DATA_W-1:0] bit_mask(input logic [IDX_W-1:0] idx);
    return DATA_W'(1) << idx;
  endfunction

  function automatic logic [DATA_W-1:0] apply_bitop(input logic [DATA_W-1:0] d,
                                                    input bitop_t f);
    logic [DATA_W-1:0] m;
    m = bit_mask(f.idx);
    return f.set ? (d | m) : (d & ~m);
  endfunction

endpackage

// File: rtl/zpb_decode.sv
module zpb_decode
  import zpb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opcode,
  input  logic              accept,
  output logic              legal,
  output bitop_t            fields_q
);

  bitop_t fields_now;

  always_comb begin
    legal      = op_is_legal(opcode);
    fields_now = op_fields(opcode);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fields_q <= '0;
    end else if (accept) begin
      fields_q <= fields_now;
    end
  end

  // A legal start must latch bit 7 and bits 6:4 of the opcode.
  a_r3_fields_latched: assert property (@(posedge clk) disable iff (rst)
    accept |=> (fields_q.idx == $past(opcode[6:4]) && fields_q.set == $past(opcode[7])));

endmodule

// File: rtl/zpb_fsm.sv
module zpb_fsm
  import zpb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       legal,
  output seq_state_t state_q,
  output logic       accept,
  output logic       illegal,
  output logic       done
);

  seq_state_t state_d;
  logic       idle;

  always_comb begin
    idle    = (state_q == ST_IDLE);
    accept  = idle && start && legal;
    illegal = idle && start && !legal;
    done    = (state_q == ST_WRITE);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_OPND;
      ST_OPND:  state_d = ST_READ;
      ST_READ:  state_d = ST_DUMMY;
      ST_DUMMY: state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  a_r1_illegal_stays_idle: assert property (@(posedge clk) disable iff (rst)
    illegal |=> state_q == ST_IDLE);

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_then_idle: assert property (@(posedge clk) disable iff (rst)
    done |=> state_q == ST_IDLE);

  a_r9_busy_no_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !idle) |=> state_q != ST_OPND);

endmodule

// File: rtl/zpb_datapath.sv
module zpb_datapath
  import zpb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-DATA_W-1:0] ZP_PAGE = '0
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  seq_state_t        state_q,
  input  logic [ADDR_W-1:0] pc,
  input  bitop_t            fields_q,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata
);

  logic [ADDR_W-1:0] opnd_addr_q;
  logic [DATA_W-1:0] zp_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] zp_addr;
  logic [DATA_W-1:0] new_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_addr_q <= '0;
      zp_q        <= '0;
      data_q      <= '0;
    end else begin
      if (accept)               opnd_addr_q <= pc + ADDR_W'(1);
      if (state_q == ST_OPND)   zp_q        <= mem_rdata;
      if (state_q == ST_READ)   data_q      <= mem_rdata;
    end
  end

  always_comb begin
    zp_addr   = {ZP_PAGE, zp_q};
    new_byte  = apply_bitop(data_q, fields_q);
    mem_addr  = '0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = '0;
    unique case (state_q)
      ST_OPND: begin
        mem_rd   = 1'b1;
        mem_addr = opnd_addr_q;
      end
      ST_READ, ST_DUMMY: begin
        mem_rd   = 1'b1;
        mem_addr = zp_addr;
      end
      ST_WRITE: begin
        mem_wr    = 1'b1;
        mem_addr  = zp_addr;
        mem_wdata = new_byte;
      end
      default: ;
    endcase
  end

  a_r5_dummy_same_addr: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DUMMY) |-> (mem_rd && mem_addr == $past(mem_addr)));

  a_r5_zero_page: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ) |-> mem_addr[ADDR_W-1:DATA_W] == ZP_PAGE);

  a_r6_other_bits_kept: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (((mem_wdata ^ $past(mem_rdata, 2)) & ~bit_mask(fields_q.idx)) == '0));

  a_r2_bit_forced: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_wdata[fields_q.idx] == fields_q.set);

endmodule

// File: rtl/zp_bitop_seq.sv
module zp_bitop_seq
  import zpb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-DATA_W-1:0] ZP_PAGE = '0
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] opcode,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              illegal
);

  logic       legal;
  logic       accept;
  bitop_t     fields_q;
  seq_state_t state_q;

  zpb_decode i_decode (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .accept   (accept),
    .legal    (legal),
    .fields_q (fields_q)
  );

  zpb_fsm i_fsm (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .legal   (legal),
    .state_q (state_q),
    .accept  (accept),
    .illegal (illegal),
    .done    (done)
  );

  zpb_datapath #(
    .ADDR_W  (ADDR_W),
    .ZP_PAGE (ZP_PAGE)
  ) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .state_q   (state_q),
    .pc        (pc),
    .fields_q  (fields_q),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata)
  );

  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r8_done_on_write: assert property (@(posedge clk) disable iff (rst)
    done |-> mem_wr);

  a_r7_write_after_reads: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ($past(mem_rd, 1) && $past(mem_rd, 2) && $past(mem_rd, 3)));

  a_r1_illegal_no_bus: assert property (@(posedge clk) disable iff (rst)
    illegal |=> (!mem_rd && !mem_wr));

  a_r4_operand_fetch: assert property (@(posedge clk) disable iff (rst)
    accept |=> (mem_rd && mem_addr == $past(pc) + ADDR_W'(1)));

endmodule

// File: tb/test_zp_bitop_seq.sv
`timescale 1ns/1ps
module test_zp_bitop_seq;

  localparam time CLK_T = 20ns;
  localparam int  MEM_N = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] pc = 16'h0100;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, done, illegal;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0] mem    [MEM_N];
  logic [7:0] refmem [MEM_N];

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  zp_bitop_seq i_zp_bitop_seq (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .pc(pc),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .illegal(illegal)
  );

  assign mem_rdata = mem[mem_addr[8:0]];

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[8:0]] <= mem_wdata;
  end

  // Reference model: phase 0 idle, phases 2..5 are the instruction cycles.
  int        phase = 0;
  logic [7:0]  m_op;
  logic [15:0] m_pc;
  logic [7:0]  m_zp;
  logic [7:0]  m_data;

  function automatic logic [7:0] expect_byte(input logic [7:0] d, input logic [7:0] op);
    int n;
    n = int'(op[6:4]);
    if (op[7]) return d | (8'd1 << n);
    return d & ~(8'd1 << n);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      phase = 0;
    end else begin
      case (phase)
        0: if (start && opcode[3:0] == 4'h7) begin
             m_op = opcode; m_pc = pc; phase = 2;
           end
        2: begin m_zp = refmem[9'(m_pc + 16'd1)]; phase = 3; end
        3: begin m_data = refmem[{1'b0, m_zp}]; phase = 4; end
        4: phase = 5;
        5: begin refmem[{1'b0, m_zp}] = expect_byte(m_data, m_op); phase = 0; end
        default: phase = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (!rst && !finished) begin
      logic e_rd, e_wr, e_ill;
      e_rd  = (phase >= 2 && phase <= 4);
      e_wr  = (phase == 5);
      e_ill = (phase == 0) && start && (opcode[3:0] != 4'h7);
      chk(mem_rd == e_rd, "R7", "mem_rd", 32'(mem_rd), 32'(e_rd));
      chk(mem_wr == e_wr, "R7", "mem_wr", 32'(mem_wr), 32'(e_wr));
      chk(done == e_wr, "R8", "done", 32'(done), 32'(e_wr));
      chk(illegal == e_ill, "R1", "illegal", 32'(illegal), 32'(e_ill));
      if (phase == 2)
        chk(mem_addr == m_pc + 16'd1, "R4", "operand addr", 32'(mem_addr), 32'(m_pc + 16'd1));
      if (phase >= 3)
        chk(mem_addr == {8'h00, m_zp}, "R5", "zp addr", 32'(mem_addr), 32'({8'h00, m_zp}));
      if (phase == 5)
        chk(mem_wdata == expect_byte(m_data, m_op), (m_op[7] ? "R2" : "R3"), "wdata",
            32'(mem_wdata), 32'(expect_byte(m_data, m_op)));
    end
  end

  task automatic put_operand(input logic [15:0] p, input logic [7:0] zp);
    mem[9'(p + 16'd1)]    = zp;
    refmem[9'(p + 16'd1)] = zp;
  endtask

  task automatic put_zp(input logic [7:0] zp, input logic [7:0] d);
    mem[{1'b0, zp}]    = d;
    refmem[{1'b0, zp}] = d;
  endtask

  task automatic run_op(input logic [7:0] op, input logic [15:0] p);
    start = 1'b1; opcode = op; pc = p;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) begin
      mem[i]    = 8'(i * 37 + 11);
      refmem[i] = 8'(i * 37 + 11);
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    #2;
    chk(!mem_rd && !mem_wr && !done && !illegal, "R10", "outputs in reset",
        {28'd0, mem_rd, mem_wr, done, illegal}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R2, R3: all sixteen legal encodings over several data patterns
    for (int k = 0; k < 16; k++) begin
      logic [7:0] zp;
      logic [15:0] p;
      zp = (k == 0) ? 8'h00 : (k == 15) ? 8'hFF : 8'(k * 17 + 3);
      p  = 16'h0100 + 16'(k * 9);
      put_operand(p, zp);
      case (k % 4)
        0: put_zp(zp, 8'h00);
        1: put_zp(zp, 8'hFF);
        2: put_zp(zp, 8'hA5);
        default: put_zp(zp, 8'h5A);
      endcase
      run_op({k[3:0], 4'h7}, p);
    end

    // R1: illegal opcodes
    run_op(8'h00, 16'h0180);
    run_op(8'h06, 16'h0180);
    run_op(8'hF8, 16'h0180);
    run_op(8'h1F, 16'h0180);

    // R9: start held while busy with other opcodes
    put_operand(16'h0190, 8'h40);
    put_zp(8'h40, 8'h0F);
    start = 1'b1; opcode = 8'hB7; pc = 16'h0190;
    @(negedge clk); opcode = 8'h07;
    @(negedge clk); opcode = 8'hF7;
    @(negedge clk); opcode = 8'h00;
    @(negedge clk); start = 1'b0;
    @(negedge clk);

    // R8: back-to-back instructions on the same byte
    put_operand(16'h01A0, 8'h41);
    put_zp(8'h41, 8'h00);
    run_op(8'hC7, 16'h01A0);
    run_op(8'hD7, 16'h01A0);
    run_op(8'h47, 16'h01A0);

    // R10: reset in the middle of an instruction; no write may happen
    put_operand(16'h01B0, 8'h42);
    put_zp(8'h42, 8'h00);
    start = 1'b1; opcode = 8'hF7; pc = 16'h01B0;
    @(negedge clk); start = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); #2;
    chk(!mem_rd && !mem_wr && !done, "R10", "strobes after mid reset",
        {29'd0, mem_rd, mem_wr, done}, 32'd0);
    @(negedge clk); rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(mem[9'h042] == 8'h00, "R10", "byte untouched after reset", 32'(mem[9'h042]), 32'h0);

    // R6: whole memory image against the model
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < MEM_N; i++) if (mem[i] !== refmem[i]) bad++;
      chk(bad == 0, "R6", "memory mismatches", 32'(bad), 32'd0);
    end
    chk(mem[9'h041] == 8'h20, "R6", "back-to-back result", 32'(mem[9'h041]), 32'h20);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_T * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule